// File: doc/BRIEF.md
# Configurable-Width UART Receiver

This block turns an asynchronous serial line into parallel bytes. It watches the line for a falling edge and confirms the start bit half a bit later. It then takes one sample from the middle of each following bit. The data bits come least significant first and are collected in a shift register. When the first stop bit is sampled, the frame is moved into a receive buffer and a receive-complete flag is raised. The flag stays up until a consumer pulses the read strobe.

The data width can be set to 5, 6, 7 or 8 bits. The bits of the buffer above the configured width always read as zero. An optional parity bit sits between the last data bit and the stop bit. Each frame is stored together with three flags: a parity-error flag, a frame-error flag for a low stop bit, and an overrun flag for the case where the previous frame was never read.

A divider outside the block supplies the bit-sample enable, `sample_tick`. It pulses once per half bit period, so there are two ticks per bit. The receiver moves only on ticks and looks at the line only while `rx_en` is high. It never drives the line.

The controller runs through five states:
- IDLE waits for a low line on a tick and then goes to START.
- START returns to IDLE if the line is high on the next tick, and otherwise goes to DATA.
- DATA samples on every second tick. After the last data bit it goes to PARITY when parity is enabled, and to STOP when it is not.
- PARITY samples the parity bit and goes to STOP.
- STOP samples the first stop bit, commits the frame and returns to IDLE.

Dropping `rx_en` sends any state back to IDLE.

Top module: `uart_rx_frame`

## Requirements
- R1: A low line on a tick in IDLE only counts as a start bit if the line is still low on the next tick. If the line is high by then, the receiver returns to IDLE and no frame is committed.
- R2: The data bits are sampled once per bit, on the second tick of each bit, and are taken least significant bit first. The width is set by `cfg_width`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: Any bits of `rx_data` above the configured width read as zero, whatever the line carried.
- R4: The frame is committed on the tick that samples the first stop bit, and `rx_done` goes high on the next clock edge. A second stop bit is neither waited for nor examined.
- R5: When `cfg_par_en` is 1, the bit after the last data bit is checked as parity. `cfg_par_odd` = 0 selects even parity and 1 selects odd. `parity_err` is stored as 1 when the count of ones in the data bits and the parity bit together does not match the selected sense.
- R6: `frame_err` is stored as 1 with the frame when the first stop bit is sampled low, and as 0 when it is sampled high.
- R7: A one-cycle pulse on `rd_strobe` clears `rx_done` on the next clock edge. `rx_data` and the stored flags are left unchanged.
- R8: A frame committed while `rx_done` is still high overwrites the buffer and sets `overrun`. A frame committed while `rx_done` is low clears `overrun`.
- R9: When a commit and `rd_strobe` fall in the same cycle, the commit wins: `rx_done` stays high and `overrun` is 0.
- R10: While `rx_en` is low the line is ignored and the controller is held in IDLE. No frame is committed and the buffer keeps its contents.
- R11: After reset, `rx_done`, `rx_data`, `frame_err`, `parity_err` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial input line, idle high |
| sample_tick | input | 1 | Sample enable, one pulse per half bit period |
| cfg_width | input | 2 | Data width: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_strobe | input | 1 | Buffer read; clears `rx_done` |
| rx_done | output | 1 | Receive-complete flag |
| rx_data | output | 8 | Received data, zero-extended above the configured width |
| frame_err | output | 1 | Stop bit of the stored frame was low |
| parity_err | output | 1 | Parity check of the stored frame failed |
| overrun | output | 1 | Stored frame replaced one that was never read |

## Verification
A frame commit and a buffer read can fall in the same clock cycle. This is the one place where two functions of the block contend for the receive-complete flag and the overrun flag.

The bench provokes the collision by raising `rd_strobe` on exactly the clock that carries the tick sampling the stop bit, while an earlier frame is still unread. The result is judged at the ports: `rx_done` must remain high, `overrun` must be 0 and `rx_data` must hold the new frame. A separate case commits without any read and must set `overrun`.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int MAX_BITS = 8;
    localparam int CNT_W    = $clog2(MAX_BITS);
    localparam int CFG_W    = 2;
    localparam int MIN_BITS = MAX_BITS - (1 << CFG_W) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
    import uart_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             tick,
    input  logic             rxd,
    input  logic [CFG_W-1:0] cfg_width,
    input  logic             cfg_par_en,
    output logic             clear,
    output logic             shift_en,
    output logic             par_sample,
    output logic             commit
);
    rx_state_t        state, nxt;
    logic             phase;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] last_bit;

    assign last_bit = CNT_W'(cfg_width) + CNT_W'(MIN_BITS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= 1'b0;
            bit_cnt <= '0;
        end else begin
            state <= nxt;
            if (rx_en && tick) begin
                if (state == ST_START) begin
                    phase   <= 1'b0;
                    bit_cnt <= '0;
                end else if (state != ST_IDLE) begin
                    phase <= ~phase;
                end
                if (shift_en) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        nxt        = state;
        clear      = 1'b0;
        shift_en   = 1'b0;
        par_sample = 1'b0;
        commit     = 1'b0;
        if (!rx_en) begin
            nxt = ST_IDLE;
        end else if (tick) begin
            unique case (state)
                ST_IDLE:   if (!rxd) nxt = ST_START;
                ST_START: begin
                    clear = 1'b1;
                    nxt   = rxd ? ST_IDLE : ST_DATA;
                end
                ST_DATA: if (phase) begin
                    shift_en = 1'b1;
                    if (bit_cnt == last_bit) nxt = cfg_par_en ? ST_PARITY : ST_STOP;
                end
                ST_PARITY: if (phase) begin
                    par_sample = 1'b1;
                    nxt        = ST_STOP;
                end
                ST_STOP: if (phase) begin
                    commit = 1'b1;
                    nxt    = ST_IDLE;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // R10: a disabled receiver sits in IDLE
    a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> state == ST_IDLE);

    // R1: a start bit that is high again on the next tick is rejected
    a_r1_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && tick && state == ST_START && rxd) |=> state == ST_IDLE);

    // R4: a commit happens only from STOP and returns to IDLE
    a_r4_commit_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> state == ST_IDLE);
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
    import uart_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                shift_en,
    input  logic                par_sample,
    input  logic                rxd,
    input  logic [CFG_W-1:0]    cfg_width,
    input  logic                cfg_par_odd,
    output logic [MAX_BITS-1:0] data_aligned,
    output logic                perr
);
    logic [MAX_BITS-1:0] sreg;
    logic                par_acc;
    logic [CFG_W-1:0]    pad;

    // Data enters at the MSB and moves down. After W bits the frame fills
    // the top W positions, and shifting right by the unused count aligns it.
    assign pad          = CFG_W'((1 << CFG_W) - 1) - cfg_width;
    assign data_aligned = sreg >> pad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg    <= '0;
            par_acc <= 1'b0;
            perr    <= 1'b0;
        end else if (clear) begin
            sreg    <= '0;
            par_acc <= 1'b0;
            perr    <= 1'b0;
        end else begin
            if (shift_en) begin
                sreg    <= {rxd, sreg[MAX_BITS-1:1]};
                par_acc <= par_acc ^ rxd;
            end
            if (par_sample) perr <= (par_acc ^ rxd) != cfg_par_odd;
        end
    end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic                rd_strobe,
    input  logic                stop_bit,
    input  logic                perr_in,
    input  logic [MAX_BITS-1:0] data_in,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_done,
    output logic                frame_err,
    output logic                parity_err,
    output logic                overrun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_done    <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
            overrun    <= 1'b0;
        end else if (commit) begin
            rx_data    <= data_in;
            rx_done    <= 1'b1;
            frame_err  <= ~stop_bit;
            parity_err <= perr_in;
            overrun    <= rx_done & ~rd_strobe;
        end else if (rd_strobe) begin
            rx_done <= 1'b0;
        end
    end

    // R4: a committed frame raises the receive-complete flag
    a_r4_done_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> rx_done);

    // R7: a read without a commit clears the flag and keeps the data
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !commit) |=> (!rx_done && $stable(rx_data)));

    // R8: committing over an unread frame reports overrun
    a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && rx_done && !rd_strobe) |=> overrun);

    // R9: a commit colliding with a read leaves the flag set and no overrun
    a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && rd_strobe) |=> (rx_done && !overrun));
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_en,
    input  logic                rxd,
    input  logic                sample_tick,
    input  logic [CFG_W-1:0]    cfg_width,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                rd_strobe,
    output logic                rx_done,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                frame_err,
    output logic                parity_err,
    output logic                overrun
);
    logic                clear, shift_en, par_sample, commit, perr;
    logic [MAX_BITS-1:0] data_aligned;

    uart_rx_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_en      (rx_en),
        .tick       (sample_tick),
        .rxd        (rxd),
        .cfg_width  (cfg_width),
        .cfg_par_en (cfg_par_en),
        .clear      (clear),
        .shift_en   (shift_en),
        .par_sample (par_sample),
        .commit     (commit)
    );

    uart_rx_shift shift_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear),
        .shift_en     (shift_en),
        .par_sample   (par_sample),
        .rxd          (rxd),
        .cfg_width    (cfg_width),
        .cfg_par_odd  (cfg_par_odd),
        .data_aligned (data_aligned),
        .perr         (perr)
    );

    uart_rx_buffer buf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .rd_strobe  (rd_strobe),
        .stop_bit   (rxd),
        .perr_in    (perr),
        .data_in    (data_aligned),
        .rx_data    (rx_data),
        .rx_done    (rx_done),
        .frame_err  (frame_err),
        .parity_err (parity_err),
        .overrun    (overrun)
    );
endmodule

// File: tb/uart_rx_frame_tb.sv
module uart_rx_frame_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;

    // {width, par_en, par_odd, par_bit, stop_bit, sent_data, exp_data, exp_ferr, exp_perr}
    localparam logic [23:0] VEC [NVEC] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 1'b0, 1'b0},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h1F, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h2A, 8'h2A, 1'b0, 1'b0},
        {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 8'h55, 8'h55, 1'b0, 1'b0},
        {2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 8'h01, 8'h01, 1'b0, 1'b1},
        {2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h03, 8'h03, 1'b0, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b1, 1'b0},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hF0, 8'h10, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       rxd = 1'b1;
    logic       sample_tick = 1'b0;
    logic [1:0] cfg_width = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       rx_done, frame_err, parity_err, overrun;
    logic [7:0] rx_data;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_frame dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .rxd         (rxd),
        .sample_tick (sample_tick),
        .cfg_width   (cfg_width),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .rd_strobe   (rd_strobe),
        .rx_done     (rx_done),
        .rx_data     (rx_data),
        .frame_err   (frame_err),
        .parity_err  (parity_err),
        .overrun     (overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one tick pulse, then three idle cycles; ends on a falling edge
    task automatic do_tick(input bit rd_with);
        @(negedge clk);
        sample_tick = 1'b1;
        rd_strobe   = rd_with;
        @(negedge clk);
        sample_tick = 1'b0;
        rd_strobe   = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [1:0] w,
                              input bit pen, input bit podd, input bit pbit,
                              input bit stopv, input bit rd_last);
        cfg_width   = w;
        cfg_par_en  = pen;
        cfg_par_odd = podd;
        rxd = 1'b0;
        do_tick(1'b0); do_tick(1'b0);
        for (int i = 0; i < int'(w) + 5; i++) begin
            rxd = d[i];
            do_tick(1'b0); do_tick(1'b0);
        end
        if (pen) begin
            rxd = pbit;
            do_tick(1'b0); do_tick(1'b0);
        end
        rxd = stopv;
        do_tick(1'b0); do_tick(rd_last);
        rxd = 1'b1;
    endtask

    task automatic idle_ticks(input int n);
        rxd = 1'b1;
        for (int i = 0; i < n; i++) do_tick(1'b0);
    endtask

    task automatic read_buf();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset values
        check("R11 done", rx_done, 0);
        check("R11 data", rx_data, 0);
        check("R11 flags", {frame_err, parity_err, overrun}, 0);
        rst_n = 1'b1;
        rx_en = 1'b1;
        idle_ticks(3);

        for (int v = 0; v < NVEC; v++) begin
            send_frame(VEC[v][17:10], VEC[v][23:22], VEC[v][21], VEC[v][20],
                       VEC[v][19], VEC[v][18], 1'b0);
            // R4: flag up straight after the first stop bit
            check($sformatf("R4 done v%0d", v), rx_done, 1);
            // R2 R3: data LSB first, upper bits zero
            check($sformatf("R2/R3 data v%0d", v), rx_data, VEC[v][9:2]);
            check($sformatf("R6 frame_err v%0d", v), frame_err, VEC[v][1]);
            check($sformatf("R5 parity_err v%0d", v), parity_err, VEC[v][0]);
            check($sformatf("R8 no overrun v%0d", v), overrun, 0);
            read_buf();
            // R7: read clears the flag, data kept
            check($sformatf("R7 cleared v%0d", v), rx_done, 0);
            check($sformatf("R7 data kept v%0d", v), rx_data, VEC[v][9:2]);
            idle_ticks(2);
        end

        // R1: glitch shorter than half a bit is rejected
        rxd = 1'b0; do_tick(1'b0);
        rxd = 1'b1;
        idle_ticks(40);
        check("R1 glitch no frame", rx_done, 0);
        check("R1 buffer kept", rx_data, 8'h10);

        // R10: disabled receiver ignores a whole frame
        rx_en = 1'b0;
        send_frame(8'h77, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        idle_ticks(2);
        check("R10 no frame when off", rx_done, 0);
        check("R10 buffer kept", rx_data, 8'h10);
        rx_en = 1'b1;
        idle_ticks(2);

        // R4: second stop bit not awaited; next frame follows a single high tick pair
        send_frame(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R4 frame A", rx_data, 8'h5A);
        // R8: second frame without a read
        idle_ticks(2);
        send_frame(8'hC3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 overrun set", overrun, 1);
        check("R8 data replaced", rx_data, 8'hC3);
        check("R8 done", rx_done, 1);

        // R9: read in the commit cycle while previous frame unread
        idle_ticks(2);
        send_frame(8'h96, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R9 done held", rx_done, 1);
        check("R9 no overrun", overrun, 0);
        check("R9 data new", rx_data, 8'h96);

        // R8: commit after a read clears overrun
        read_buf();
        idle_ticks(2);
        send_frame(8'h0F, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R8 overrun clear", overrun, 0);
        check("R3 six-bit mask", rx_data, 8'h0F);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule